// File: doc/BRIEF.md
# CAN Bypass-Mode Message Buffer

This block holds the two message buffers a CAN controller uses when it runs without its message memory. A CPU sees a small set of 16-bit registers. One buffer is for transmit. Writing its busy flag asks for a send, and the same flag locks the buffer until the frame has gone out. The engine gets the frame loaded on the first idle bus cycle after the request. The other buffer is for receive. It takes a copy of the protocol shift register at the end of every received frame, with no filtering. The CPU can also take a snapshot of the shift register at any time, including in the middle of a frame.

The serial engine is not part of this block. It is seen only through strobes:
- an idle indication
- a load pulse driven by this block
- success, lost-arbitration and error strobes for transmit
- a receive-complete strobe, together with the parallel contents of the shift register

The ready output is held high all the time, because this mode never stalls the bus.

Top module: `canbm_buf`

## Requirements
- R1: Registers are 16-bit words at word index bus_addr[7:1]. bus_be[0] writes the low byte (even address) and bus_be[1] writes the high byte (odd address). The word map is as follows. Word 0 is the transmit command, with busy in bit 15. Word 1 is the transmit identifier in bits 10:0. Word 2 is the transmit DLC in bits 3:0. Words 3 to 6 are transmit data, where word 3+k holds frame byte 2k in its low byte and byte 2k+1 in its high byte. Words 16 to 22 have the same layout for the receive buffer. Data byte i travels on bits 8i+7:8i of the parallel frame buses.
- R2: Writing 1 to transmit busy requests a send, and tx_pending and command bit 15 read 1 while it is pending. Writes to the transmit identifier, DLC and data words are ignored while busy is set.
- R3: When busy is set, eng_idle is high and no frame is in flight, eng_load goes high in the same cycle. At that point tx_id, tx_dlc and tx_data carry the buffer contents.
- R4: An eng_tx_ok strobe for the frame in flight clears busy, which unlocks the transmit buffer.
- R5: Writing 0 to transmit busy clears it at once, and this aborts the send. A later eng_arb_lost or eng_err then causes no new load.
- R6: An eng_arb_lost or eng_err strobe while busy is still set keeps busy set. The buffer is loaded again at the next idle bus.
- R7: Every eng_rx_done copies sr_id, sr_dlc and sr_data into the receive buffer unconditionally and sets new-data.
- R8: Writing 1 to bit 15 of the receive command word (word 16) copies the shift-register buses into the receive buffer at once. New-data and message-lost are left unchanged.
- R9: The ready output is always 1.
- R10: An eng_rx_done that arrives while new-data is set also sets message-lost. A read of the receive control word (word 18) with bus_rd high clears both flags.
- R11: The receive control word reads new-data in bit 15, message-lost in bit 14 and the DLC in bits 3:0, with every other bit zero. The lower bits of the receive command word (message number and mask bits) have no effect, and that word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe (used for the acknowledge side effect) |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_be | input | 2 | Byte enables: bit 0 is the even/low byte, bit 1 is the odd/high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| eng_idle | input | 1 | Bus idle indication from the engine |
| eng_load | output | 1 | Load the transmit buffer into the shift register |
| tx_id | output | 11 | Transmit identifier |
| tx_dlc | output | 4 | Transmit DLC |
| tx_data | output | 64 | Transmit data bytes |
| eng_tx_ok | input | 1 | Frame sent successfully |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_err | input | 1 | Bus error during transmit |
| eng_rx_done | input | 1 | Reception completed |
| sr_id | input | 11 | Shift-register identifier |
| sr_dlc | input | 4 | Shift-register DLC |
| sr_data | input | 64 | Shift-register data bytes |
| tx_pending | output | 1 | Transmit busy flag |
| rx_newdat | output | 1 | New-data flag |
| rx_msglst | output | 1 | Message-lost flag |
| ready | output | 1 | Wait/ready output, held high |

## Verification
The transmit path is tried with four patterns: a clean send, a send hit by lost arbitration, an abort after the frame has been loaded, and an abort before any idle bus. The clean send shows that the load is timed to the idle bus. The retry case and the post-load abort separate "busy stays set" from "busy is cleared" when the same engine strobe arrives. The receive path is fed frames with distinct identifiers and byte values, delivered both back to back and after an acknowledge, so that byte-lane order, the message-lost condition and the acknowledge clear can each be seen. A mid-frame snapshot, written with the mask and number bits set, separates the snapshot copy from a completed reception, because new-data must not move.

// File: rtl/canbm_buf.sv
module canbm_buf #(
  parameter int DATA_BYTES = 8,
  parameter int ID_W = 11,
  parameter int RX_BASE = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [7:0]              bus_addr,
  input  logic [1:0]              bus_be,
  input  logic [15:0]             bus_wdata,
  output logic [15:0]             bus_rdata,
  input  logic                    eng_idle,
  output logic                    eng_load,
  output logic [ID_W-1:0]         tx_id,
  output logic [3:0]              tx_dlc,
  output logic [8*DATA_BYTES-1:0] tx_data,
  input  logic                    eng_tx_ok,
  input  logic                    eng_arb_lost,
  input  logic                    eng_err,
  input  logic                    eng_rx_done,
  input  logic [ID_W-1:0]         sr_id,
  input  logic [3:0]              sr_dlc,
  input  logic [8*DATA_BYTES-1:0] sr_data,
  output logic                    tx_pending,
  output logic                    rx_newdat,
  output logic                    rx_msglst,
  output logic                    ready
);
  localparam int NW = DATA_BYTES / 2;
  localparam int IDX_DAT = 3;
  localparam logic [6:0] RXB = 7'(RX_BASE);
  localparam logic [15:0] ID_MASK = 16'((32'd1 << ID_W) - 1);

  function automatic logic [15:0] lane(input logic [15:0] old, input logic [15:0] wd,
                                       input logic [1:0] be);
    return {be[1] ? wd[15:8] : old[15:8], be[0] ? wd[7:0] : old[7:0]};
  endfunction

  logic [6:0]  widx;
  logic        tx_busy, inflight, nd_q, ml_q;
  logic [15:0] txid_w, rxid_w;
  logic [3:0]  txdlc, rxdlc;
  logic [15:0] txw [NW];
  logic [15:0] rxw [NW];
  logic        cmd_set, cmd_clr, buf_wr, snap, ack, eng_evt;

  assign widx    = bus_addr[7:1];
  assign cmd_set = bus_wr && widx == 7'd0 && bus_be[1] && bus_wdata[15];
  assign cmd_clr = bus_wr && widx == 7'd0 && bus_be[1] && !bus_wdata[15];
  assign buf_wr  = bus_wr && !tx_busy;
  assign snap    = bus_wr && widx == RXB && bus_be[1] && bus_wdata[15];
  assign ack     = bus_rd && widx == RXB + 7'd2;
  assign eng_evt = eng_tx_ok | eng_arb_lost | eng_err;

  assign eng_load   = tx_busy && !inflight && eng_idle;
  assign tx_pending = tx_busy;
  assign rx_newdat  = nd_q;
  assign rx_msglst  = ml_q;
  assign ready      = 1'b1;
  assign tx_id      = txid_w[ID_W-1:0];
  assign tx_dlc     = txdlc;

  for (genvar g = 0; g < NW; g++) begin : g_txd
    assign tx_data[16*g +: 16] = txw[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      inflight <= 1'b0;
    end else begin
      if (cmd_clr) tx_busy <= 1'b0;
      else if (cmd_set && !tx_busy) tx_busy <= 1'b1;
      else if (inflight && eng_tx_ok) tx_busy <= 1'b0;
      if (eng_load) inflight <= 1'b1;
      else if (eng_evt) inflight <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txid_w <= '0;
      txdlc  <= '0;
      for (int k = 0; k < NW; k++) txw[k] <= '0;
    end else if (buf_wr) begin
      if (widx == 7'd1) txid_w <= lane(txid_w, bus_wdata, bus_be) & ID_MASK;
      if (widx == 7'd2 && bus_be[0]) txdlc <= bus_wdata[3:0];
      for (int k = 0; k < NW; k++)
        if (widx == 7'(IDX_DAT + k)) txw[k] <= lane(txw[k], bus_wdata, bus_be);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxid_w <= '0;
      rxdlc  <= '0;
      nd_q   <= 1'b0;
      ml_q   <= 1'b0;
      for (int k = 0; k < NW; k++) rxw[k] <= '0;
    end else begin
      if (eng_rx_done || snap) begin
        rxid_w <= 16'(sr_id);
        rxdlc  <= sr_dlc;
        for (int k = 0; k < NW; k++) rxw[k] <= sr_data[16*k +: 16];
      end
      if (eng_rx_done) nd_q <= 1'b1;
      else if (ack) nd_q <= 1'b0;
      if (eng_rx_done && nd_q) ml_q <= 1'b1;
      else if (ack) ml_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (widx == 7'd0) bus_rdata = {tx_busy, 15'b0};
    if (widx == 7'd1) bus_rdata = txid_w;
    if (widx == 7'd2) bus_rdata = {12'b0, txdlc};
    if (widx == RXB + 7'd1) bus_rdata = rxid_w;
    if (widx == RXB + 7'd2) bus_rdata = {nd_q, ml_q, 10'b0, rxdlc};
    for (int k = 0; k < NW; k++) begin
      if (widx == 7'(IDX_DAT + k)) bus_rdata = txw[k];
      if (widx == RXB + 7'(IDX_DAT + k)) bus_rdata = rxw[k];
    end
  end
endmodule

module canbm_buf_chk #(
  parameter int ID_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic            eng_idle,
  input logic            eng_load,
  input logic            eng_tx_ok,
  input logic            eng_arb_lost,
  input logic            eng_err,
  input logic            eng_rx_done,
  input logic [ID_W-1:0] sr_id,
  input logic [ID_W-1:0] tx_id,
  input logic            tx_pending,
  input logic            rx_newdat,
  input logic            rx_msglst,
  input logic            ready,
  input logic            inflight,
  input logic [15:0]     rxid_w
);
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n) ready);

  assert_load_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |-> eng_idle && tx_pending);

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pending && bus_wr && bus_addr[7:1] == 7'd1 |=> $stable(tx_id));

  assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight && tx_pending && eng_tx_ok && !(bus_wr && bus_addr[7:1] == 7'd0) |=> !tx_pending);

  assert_retry_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pending && (eng_arb_lost || eng_err) && !eng_tx_ok && !bus_wr |=> tx_pending);

  assert_rx_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_done |=> rx_newdat && rxid_w[ID_W-1:0] == $past(sr_id));

  assert_msglst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_done && rx_newdat |=> rx_msglst);
endmodule

bind canbm_buf canbm_buf_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .eng_idle(eng_idle), .eng_load(eng_load), .eng_tx_ok(eng_tx_ok),
  .eng_arb_lost(eng_arb_lost), .eng_err(eng_err), .eng_rx_done(eng_rx_done),
  .sr_id(sr_id), .tx_id(tx_id), .tx_pending(tx_pending), .rx_newdat(rx_newdat),
  .rx_msglst(rx_msglst), .ready(ready), .inflight(inflight), .rxid_w(rxid_w)
);

// File: tb/canbm_buf_tb.sv
`timescale 1ns/1ps
module canbm_buf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_be = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic eng_idle = 0, eng_load;
  logic [10:0] tx_id;
  logic [3:0] tx_dlc;
  logic [63:0] tx_data;
  logic eng_tx_ok = 0, eng_arb_lost = 0, eng_err = 0, eng_rx_done = 0;
  logic [10:0] sr_id = 0;
  logic [3:0] sr_dlc = 0;
  logic [63:0] sr_data = 0;
  logic tx_pending, rx_newdat, rx_msglst, ready;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  canbm_buf dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic ackf, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = ackf;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse_rx(input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] dat);
    @(negedge clk);
    sr_id = id; sr_dlc = dlc; sr_data = dat; eng_rx_done = 1;
    @(negedge clk);
    eng_rx_done = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R2 reset pending", tx_pending, 0);
    chk("R10 reset newdat", rx_newdat, 0);
    chk("R9 ready", ready, 1);
    chk("R3 reset load", eng_load, 0);
    rd(8'h00, 0, d); chk("R2 reset cmd", d, 0);
  endtask

  task automatic t_lanes;
    logic [15:0] d;
    eng_idle = 0;
    wr(8'h02, 16'h05A3, 2'b11); rd(8'h02, 0, d); chk("R1 id word", d, 16'h05A3);
    wr(8'h02, 16'hFF12, 2'b01); rd(8'h02, 0, d); chk("R1 low lane", d, 16'h0512);
    wr(8'h03, 16'h0700, 2'b10); rd(8'h02, 0, d); chk("R1 high lane", d, 16'h0712);
    wr(8'h06, 16'hBBAA, 2'b11);
    chk("R1 data bytes 0,1", tx_data[15:0], 16'hBBAA);
    wr(8'h0C, 16'h4433, 2'b11);
    chk("R1 data bytes 6,7", tx_data[63:48], 16'h4433);
    wr(8'h04, 16'hFFF9, 2'b11); rd(8'h04, 0, d);
    chk("R1 dlc", {d, 12'b0, tx_dlc}, {16'h0009, 16'h0009});
  endtask

  task automatic t_tx_basic;
    logic [15:0] d;
    eng_idle = 0;
    wr(8'h00, 16'h8000, 2'b10);
    chk("R2 pending", tx_pending, 1);
    rd(8'h00, 0, d); chk("R2 cmd readback", d, 16'h8000);
    chk("R3 no load while bus busy", eng_load, 0);
    wr(8'h02, 16'h0123, 2'b11); rd(8'h02, 0, d); chk("R2 lock", d, 16'h0712);
    @(negedge clk); eng_idle = 1; #1;
    chk("R3 load on idle", eng_load, 1);
    chk("R3 tx id", tx_id, 11'h712);
    @(negedge clk); chk("R3 single load", eng_load, 0);
    eng_idle = 0; eng_tx_ok = 1;
    @(negedge clk); eng_tx_ok = 0;
    chk("R4 done clears", tx_pending, 0);
    wr(8'h02, 16'h0123, 2'b11); rd(8'h02, 0, d); chk("R4 unlock", d, 16'h0123);
  endtask

  task automatic t_retry;
    eng_idle = 0;
    wr(8'h00, 16'h8000, 2'b10);
    @(negedge clk); eng_idle = 1; #1; chk("R3 load", eng_load, 1);
    @(negedge clk); eng_idle = 0; eng_arb_lost = 1;
    @(negedge clk); eng_arb_lost = 0;
    chk("R6 still pending", tx_pending, 1);
    chk("R6 no load until idle", eng_load, 0);
    eng_idle = 1; #1; chk("R6 reload", eng_load, 1);
    @(negedge clk); eng_idle = 0; eng_err = 1;
    @(negedge clk); eng_err = 0;
    chk("R6 pending after error", tx_pending, 1);
    eng_idle = 1; #1; chk("R6 reload after error", eng_load, 1);
    @(negedge clk); eng_idle = 0; eng_tx_ok = 1;
    @(negedge clk); eng_tx_ok = 0;
    chk("R4 done after retries", tx_pending, 0);
  endtask

  task automatic t_abort;
    eng_idle = 0;
    wr(8'h00, 16'h8000, 2'b10);
    @(negedge clk); eng_idle = 1; #1; chk("R3 load", eng_load, 1);
    @(negedge clk); eng_idle = 0;
    wr(8'h00, 16'h0000, 2'b10);
    chk("R5 abort clears", tx_pending, 0);
    eng_err = 1;
    @(negedge clk); eng_err = 0; eng_idle = 1; #1;
    chk("R5 no retransmit", eng_load, 0);
    @(negedge clk); chk("R5 stays clear", tx_pending, 0);
    eng_idle = 0;
    wr(8'h00, 16'h8000, 2'b10);
    wr(8'h00, 16'h0000, 2'b10);
    @(negedge clk); eng_idle = 1; #1;
    chk("R5 abort before load", eng_load, 0);
    @(negedge clk); eng_idle = 0;
  endtask

  task automatic t_rx;
    logic [15:0] d;
    pulse_rx(11'h3C5, 4'd8, 64'h1122334455667788);
    chk("R7 newdat", rx_newdat, 1);
    chk("R10 no msglst on first", rx_msglst, 0);
    rd(8'h22, 0, d); chk("R7 rx id", d, 16'h03C5);
    rd(8'h26, 0, d); chk("R7 rx bytes 0,1", d, 16'h7788);
    rd(8'h2C, 0, d); chk("R7 rx bytes 6,7", d, 16'h1122);
    rd(8'h24, 0, d); chk("R11 ctrl bits", d, 16'h8008);
    pulse_rx(11'h155, 4'd3, 64'hA5A5A5A5A5A5A5A5);
    chk("R10 msglst set", rx_msglst, 1);
    rd(8'h24, 1, d); chk("R11 ctrl with msglst", d, 16'hC003);
    chk("R10 ack clears newdat", rx_newdat, 0);
    chk("R10 ack clears msglst", rx_msglst, 0);
    rd(8'h24, 0, d); chk("R11 ctrl after ack", d, 16'h0003);
    pulse_rx(11'h001, 4'd1, 64'h0);
    chk("R10 no msglst after ack", rx_msglst, 0);
    rd(8'h24, 1, d);
  endtask

  task automatic t_snap;
    logic [15:0] d;
    @(negedge clk); sr_id = 11'h0AB; sr_dlc = 4'd5; sr_data = 64'h00000000DEADBEEF;
    wr(8'h20, 16'h803F, 2'b11);
    rd(8'h22, 0, d); chk("R8 snapshot id", d, 16'h00AB);
    rd(8'h26, 0, d); chk("R8 snapshot data", d, 16'hBEEF);
    chk("R8 newdat untouched", rx_newdat, 0);
    rd(8'h20, 0, d); chk("R11 rx cmd reads zero", d, 16'h0000);
    rd(8'h24, 0, d); chk("R11 ctrl after snapshot", d, 16'h0005);
    chk("R9 ready", ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_lanes;
    t_tx_basic;
    t_retry;
    t_abort;
    t_rx;
    t_snap;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule